// File: doc/BRIEF.md
# Time-Slotted Wide-Row Register File

This block holds 128 registers of 64 bits in a single-ported array whose every access moves one 256-bit row, that is, four neighbouring registers. The array is split into two 128-bit halves. The two halves always share the same address and the same cycle. A free-running four-cycle frame decides what the array does in each cycle. The first three cycles are operand reads for a group of four operations, one row per source: S1, S2 and S3. The fourth cycle writes back one gathered result row.

Collector registers capture the three operand rows of a group. In the following frame they hand lane k of each row to execution lane k, one lane per cycle. The next group's reads proceed in parallel with this hand-off. Results coming back from the execution pipeline are gathered lane by lane into a pending row, which is written with a lane mask in the next write cycle.

The S3 slot is lent to a memory request whenever the current frame holds no group that needs a third operand. A store reads a whole row through that slot. A load writes a row through it under a lane mask. Memory requests enter a small in-order queue with a ready/valid handshake and wait there until a free S3 slot comes round.

Top module: `slotted_rf`

## Requirements
- R1: After reset the slot counter reads 0 (S1). It then advances every cycle through 0 (S1), 1 (S2), 2 (S3), 3 (WR) and wraps. `grp_ready` is high exactly in slot 0.
- R2: Register number n lives in row n[6:2] and lane n[1:0]. Lane k of a row occupies bits [64k+63:64k] of every row-wide port. Bit k of a lane mask selects lane k.
- R3: A group presented with `grp_valid` in slot 0 of frame F is delivered in frame F+1. In slot k of that frame, `opr_valid` is 1, `opr_lane` is k, and `opr_a`, `opr_b` and `opr_c` carry lane k of rows `grp_src1`, `grp_src2` and `grp_src3` as they stood when read in frame F.
- R4: When a group has `grp_use_s3` low, `opr_c` is zero for all four of its lanes.
- R5: The array performs at most one access per cycle. Row writes happen only in slot 2 (loads) or slot 3 (results). A group reading a row in frame F therefore sees the old contents even if a result write to that row lands in slot 3 of frame F.
- R6: Results are gathered per lane. The row and the final lane arrive with `res_last`. In the next slot 3, exactly the lanes received are written, and the other lanes of that row keep their values.
- R7: In a slot 2 that no S3 read needs, the oldest queued memory request is served. A load writes `mem_wdata` into the lanes set in `mem_mask`. A store returns the row on `mem_rdata` with `mem_rvalid` high during slot 3 of the same frame.
- R8: A memory request is accepted when `mem_valid` and `mem_ready` are both high. `mem_ready` is low once two requests are waiting. Waiting requests are served strictly in arrival order.
- R9: A load served in frame F is visible to a group that reads the same row in frame F+1.
- R10: After reset, `opr_valid` and `mem_rvalid` are low and `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | output | 2 | Current frame slot: 0 S1, 1 S2, 2 S3, 3 WR |
| grp_ready | output | 1 | High in slot 0, when a group may be issued |
| grp_valid | input | 1 | Issue a group this frame (sampled in slot 0) |
| grp_src1 | input | 5 | Row for operand A |
| grp_src2 | input | 5 | Row for operand B |
| grp_src3 | input | 5 | Row for operand C |
| grp_use_s3 | input | 1 | Group needs operand C |
| opr_valid | output | 1 | Operand hand-off valid |
| opr_lane | output | 2 | Execution lane receiving operands |
| opr_a | output | 64 | Operand A for the lane |
| opr_b | output | 64 | Operand B for the lane |
| opr_c | output | 64 | Operand C for the lane, zero if unused |
| res_valid | input | 1 | One result lane returning |
| res_lane | input | 2 | Lane of the returning result |
| res_row | input | 5 | Destination row, taken with res_last |
| res_data | input | 64 | Result value |
| res_last | input | 1 | Final result of the group |
| mem_valid | input | 1 | Memory request valid |
| mem_ready | output | 1 | Memory request accepted this cycle |
| mem_load | input | 1 | 1 load (row write), 0 store (row read) |
| mem_row | input | 5 | Row addressed by the request |
| mem_mask | input | 4 | Lane write mask for a load |
| mem_wdata | input | 256 | Load data |
| mem_rvalid | output | 1 | Store read data valid |
| mem_rdata | output | 256 | Store read data |

## Verification
The assertions take for granted that a group's results are returned at most once per lane. They also assume that a new `res_last` never arrives while an earlier gathered row is still pending, except in slot 3, when that row is being written. The bench returns each group's results as one short burst and starts the next burst only after a write slot has passed. The bench raises `grp_valid` only in slot 0, and it keeps `mem_valid` and its fields steady until the request is taken. The design samples the group fields only in slot 0 and accepts memory requests only through the handshake, so these are the only conditions the stimulus has to respect.

// File: rtl/tsrf_pkg.sv
package tsrf_pkg;
    localparam int XLEN    = 64;
    localparam int LANES   = 4;
    localparam int NREG    = 128;
    localparam int ROW_W   = XLEN * LANES;
    localparam int NROWS   = NREG / LANES;
    localparam int ROW_AW  = $clog2(NROWS);
    localparam int LANE_AW = $clog2(LANES);
    localparam int HALVES  = 2;
    localparam int HALF_W  = ROW_W / HALVES;
    localparam int HALF_L  = LANES / HALVES;

    typedef logic [ROW_AW-1:0] row_t;
    typedef logic [ROW_W-1:0]  rowdat_t;
    typedef logic [XLEN-1:0]   word_t;
    typedef logic [LANES-1:0]  lmask_t;

    typedef enum logic [1:0] {
        SL_S1 = 2'd0,
        SL_S2 = 2'd1,
        SL_S3 = 2'd2,
        SL_WR = 2'd3
    } slot_e;

    typedef struct packed {
        logic    load;
        row_t    row;
        lmask_t  mask;
        rowdat_t data;
    } memreq_t;

    typedef struct packed {
        logic    en;
        logic    we;
        row_t    row;
        lmask_t  mask;
        rowdat_t data;
    } acc_t;

    function automatic word_t lane_of(rowdat_t r, logic [LANE_AW-1:0] k);
        return r[k*XLEN +: XLEN];
    endfunction

    function automatic slot_e next_slot(slot_e s);
        logic [1:0] t;
        t = 2'(s) + 2'd1;
        return slot_e'(t);
    endfunction
endpackage

// File: rtl/tsrf_bank.sv
module tsrf_bank #(
    parameter int LW    = 64,
    parameter int NL    = 2,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    localparam int W    = LW * NL
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] wmask,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        logic [LW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (en && we && wmask[g]) begin
                mem[addr] <= wdata[g*LW +: LW];
            end
            if (en && !we) begin
                rd_q <= mem[addr];
            end
        end

        assign rdata[g*LW +: LW] = rd_q;
    end
endmodule

// File: rtl/tsrf_memq.sv
module tsrf_memq #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  q [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] nx(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            q[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nx(wp);
            if (pop)  rp <= nx(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = q[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R8: occupancy never exceeds the queue depth
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R8: the top only takes the head when one exists
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/slotted_rf.sv
module slotted_rf
    import tsrf_pkg::*;
#(
    parameter int MQ_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    output logic [1:0]          slot,
    output logic                grp_ready,
    input  logic                grp_valid,
    input  logic [ROW_AW-1:0]   grp_src1,
    input  logic [ROW_AW-1:0]   grp_src2,
    input  logic [ROW_AW-1:0]   grp_src3,
    input  logic                grp_use_s3,
    output logic                opr_valid,
    output logic [LANE_AW-1:0]  opr_lane,
    output logic [XLEN-1:0]     opr_a,
    output logic [XLEN-1:0]     opr_b,
    output logic [XLEN-1:0]     opr_c,
    input  logic                res_valid,
    input  logic [LANE_AW-1:0]  res_lane,
    input  logic [ROW_AW-1:0]   res_row,
    input  logic [XLEN-1:0]     res_data,
    input  logic                res_last,
    input  logic                mem_valid,
    output logic                mem_ready,
    input  logic                mem_load,
    input  logic [ROW_AW-1:0]   mem_row,
    input  logic [LANES-1:0]    mem_mask,
    input  logic [ROW_W-1:0]    mem_wdata,
    output logic                mem_rvalid,
    output logic [ROW_W-1:0]    mem_rdata
);
    localparam int MQ_W = $bits(memreq_t);

    // ---------------- slot sequencer ----------------
    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SL_S1;
        else     slot_q <= next_slot(slot_q);
    end

    assign slot      = slot_q;
    assign grp_ready = (slot_q == SL_S1);

    // ---------------- current group ----------------
    logic cur_act, cur_s3;
    row_t cur_r2, cur_r3;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_act <= 1'b0;
            cur_s3  <= 1'b0;
        end else if (slot_q == SL_S1) begin
            cur_act <= grp_valid;
            cur_s3  <= grp_valid && grp_use_s3;
        end
    end

    always_ff @(posedge clk) begin
        if (slot_q == SL_S1) begin
            cur_r2 <= grp_src2;
            cur_r3 <= grp_src3;
        end
    end

    // ---------------- memory request queue ----------------
    memreq_t mq_in, mq_head;
    logic    mq_full, mq_empty, mq_push, mq_pop, s3_free;
    logic [MQ_W-1:0] mq_dout;

    assign mq_in     = '{load: mem_load, row: mem_row, mask: mem_mask, data: mem_wdata};
    assign mem_ready = !mq_full;
    assign mq_push   = mem_valid && !mq_full;
    assign s3_free   = (slot_q == SL_S3) && !(cur_act && cur_s3);
    assign mq_pop    = s3_free && !mq_empty;
    assign mq_head   = memreq_t'(mq_dout);

    tsrf_memq #(.W(MQ_W), .DEPTH(MQ_DEPTH)) u_memq (
        .clk   (clk),
        .rst   (rst),
        .push  (mq_push),
        .din   (MQ_W'(mq_in)),
        .pop   (mq_pop),
        .dout  (mq_dout),
        .full  (mq_full),
        .empty (mq_empty)
    );

    // ---------------- result gathering ----------------
    rowdat_t g_data, g_merge, pend_data;
    lmask_t  g_mask, g_onehot, pend_mask;
    row_t    pend_row;
    logic    pend_valid;

    always_comb begin
        g_merge = g_data;
        g_merge[res_lane*XLEN +: XLEN] = res_data;
        g_onehot = lmask_t'(1) << res_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_mask     <= '0;
            pend_valid <= 1'b0;
        end else begin
            if (slot_q == SL_WR && pend_valid) begin
                pend_valid <= 1'b0;
            end
            if (res_valid) begin
                if (res_last) begin
                    pend_valid <= 1'b1;
                    g_mask     <= '0;
                end else begin
                    g_mask <= g_mask | g_onehot;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (res_valid) begin
            g_data <= g_merge;
            if (res_last) begin
                pend_row  <= res_row;
                pend_mask <= g_mask | g_onehot;
                pend_data <= g_merge;
            end
        end
    end

    // ---------------- array access selection ----------------
    acc_t acc;

    always_comb begin
        acc = '0;
        unique case (slot_q)
            SL_S1: begin
                acc.en  = grp_valid;
                acc.row = grp_src1;
            end
            SL_S2: begin
                acc.en  = cur_act;
                acc.row = cur_r2;
            end
            SL_S3: begin
                if (cur_act && cur_s3) begin
                    acc.en  = 1'b1;
                    acc.row = cur_r3;
                end else if (!mq_empty) begin
                    acc.en   = 1'b1;
                    acc.we   = mq_head.load;
                    acc.row  = mq_head.row;
                    acc.mask = mq_head.mask;
                    acc.data = mq_head.data;
                end
            end
            SL_WR: begin
                acc.en   = pend_valid;
                acc.we   = pend_valid;
                acc.row  = pend_row;
                acc.mask = pend_mask;
                acc.data = pend_data;
            end
            default: acc = '0;
        endcase
    end

    rowdat_t rd_row;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        tsrf_bank #(.LW(XLEN), .NL(HALF_L), .DEPTH(NROWS), .AW(ROW_AW)) u_bank (
            .clk   (clk),
            .en    (acc.en),
            .we    (acc.we),
            .addr  (acc.row),
            .wmask (acc.mask[h*HALF_L +: HALF_L]),
            .wdata (acc.data[h*HALF_W +: HALF_W]),
            .rdata (rd_row[h*HALF_W +: HALF_W])
        );
    end

    // ---------------- collectors ----------------
    rowdat_t col_a, col_b, dlv_a, dlv_b, dlv_c;
    logic    dlv_valid, st_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid <= 1'b0;
            st_pend   <= 1'b0;
        end else begin
            st_pend <= mq_pop && !mq_head.load;
            if (slot_q == SL_WR) dlv_valid <= cur_act;
        end
    end

    always_ff @(posedge clk) begin
        unique case (slot_q)
            SL_S2: col_a <= rd_row;
            SL_S3: col_b <= rd_row;
            SL_WR: begin
                dlv_a <= col_a;
                dlv_b <= col_b;
                dlv_c <= cur_s3 ? rd_row : '0;
            end
            default: ;
        endcase
    end

    assign opr_valid  = dlv_valid;
    assign opr_lane   = slot_q;
    assign opr_a      = lane_of(dlv_a, slot_q);
    assign opr_b      = lane_of(dlv_b, slot_q);
    assign opr_c      = lane_of(dlv_c, slot_q);
    assign mem_rvalid = st_pend;
    assign mem_rdata  = rd_row;

    // ---------------- assertions ----------------
    a_r1_slot_advance: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> slot_q == next_slot($past(slot_q)));

    a_r5_write_slot: assert property (@(posedge clk) disable iff (rst)
        (acc.en && acc.we) |-> (slot_q == SL_S3 || slot_q == SL_WR));

    a_r7_store_resp_in_wr: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> slot_q == SL_WR);

    a_r3_dlv_hold: assert property (@(posedge clk) disable iff (rst)
        (opr_valid && slot_q != SL_WR) |=> opr_valid);

    a_r6_no_result_overrun: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_last && pend_valid) |-> slot_q == SL_WR);
endmodule

// File: tb/slotted_rf_tb.sv
`timescale 1ns/1ps
module slotted_rf_tb;
    import tsrf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]   slot;
    logic         grp_ready, grp_valid, grp_use_s3;
    row_t         grp_src1, grp_src2, grp_src3;
    logic         opr_valid;
    logic [1:0]   opr_lane;
    word_t        opr_a, opr_b, opr_c;
    logic         res_valid, res_last;
    logic [1:0]   res_lane;
    row_t         res_row;
    word_t        res_data;
    logic         mem_valid, mem_ready, mem_load, mem_rvalid;
    row_t         mem_row;
    lmask_t       mem_mask;
    rowdat_t      mem_wdata, mem_rdata;

    slotted_rf u_dut (
        .clk(clk), .rst(rst), .slot(slot), .grp_ready(grp_ready),
        .grp_valid(grp_valid), .grp_src1(grp_src1), .grp_src2(grp_src2),
        .grp_src3(grp_src3), .grp_use_s3(grp_use_s3),
        .opr_valid(opr_valid), .opr_lane(opr_lane), .opr_a(opr_a),
        .opr_b(opr_b), .opr_c(opr_c),
        .res_valid(res_valid), .res_lane(res_lane), .res_row(res_row),
        .res_data(res_data), .res_last(res_last),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_load(mem_load),
        .mem_row(mem_row), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    word_t rf_ref [NREG];

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R2: register n = row*4 + lane
    function automatic int regnum(int row, int lane);
        return row * 4 + lane;
    endfunction

    function automatic rowdat_t row_of(int row);
        rowdat_t r;
        for (int k = 0; k < 4; k++) r[k*64 +: 64] = rf_ref[regnum(row, k)];
        return r;
    endfunction

    function automatic word_t mkw(int n, int salt);
        return word_t'(n + 1) * 64'h9E37_79B9_7F4A_7C15 ^ word_t'(salt);
    endfunction

    task automatic wait_slot(input logic [1:0] s);
        do @(negedge clk); while (slot != s);
    endtask

    task automatic push_req(input logic ld, input int row, input lmask_t m, input rowdat_t d);
        while (!mem_ready) @(negedge clk);
        mem_valid = 1'b1; mem_load = ld; mem_row = row_t'(row);
        mem_mask = m; mem_wdata = d;
        @(negedge clk);
        mem_valid = 1'b0;
        if (ld) for (int k = 0; k < 4; k++)
            if (m[k]) rf_ref[regnum(row, k)] = d[k*64 +: 64];
    endtask

    // at slot-0 negedge of the delivery frame; ends at its slot-3 negedge
    task automatic expect_lanes(input string req, input rowdat_t ea,
                                input rowdat_t eb, input rowdat_t ec);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk(req, "opr_valid", 256'(opr_valid), 256'(1));
            chk(req, "opr_lane",  256'(opr_lane),  256'(k));
            chk(req, "opr_a", 256'(opr_a), 256'(ea[k*64 +: 64]));
            chk(req, "opr_b", 256'(opr_b), 256'(eb[k*64 +: 64]));
            chk(req, "opr_c", 256'(opr_c), 256'(ec[k*64 +: 64]));
        end
    endtask

    task automatic drive_grp(input int r1, input int r2, input int r3, input logic u3);
        grp_valid = 1'b1; grp_src1 = row_t'(r1); grp_src2 = row_t'(r2);
        grp_src3 = row_t'(r3); grp_use_s3 = u3;
    endtask

    task automatic run_group(input string req, input int r1, input int r2,
                             input int r3, input logic u3);
        rowdat_t ea, eb, ec;
        wait_slot(2'd0);
        ea = row_of(r1); eb = row_of(r2); ec = u3 ? row_of(r3) : '0;
        drive_grp(r1, r2, r3, u3);
        @(negedge clk); grp_valid = 1'b0;
        repeat (3) @(negedge clk);
        expect_lanes(req, ea, eb, ec);
    endtask

    task automatic t_reset();
        chk("R1", "slot after reset", 256'(slot), 256'(0));
        chk("R10", "opr_valid", 256'(opr_valid), 256'(0));
        chk("R10", "mem_rvalid", 256'(mem_rvalid), 256'(0));
        chk("R10", "mem_ready", 256'(mem_ready), 256'(1));
    endtask

    task automatic t_slots();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R1", "slot seq", 256'(slot), 256'((i + 1) % 4));
            chk("R1", "grp_ready", 256'(grp_ready), 256'(((i + 1) % 4) == 0));
        end
    endtask

    task automatic t_fill();
        for (int r = 0; r < NROWS; r++) begin
            rowdat_t d;
            for (int k = 0; k < 4; k++) d[k*64 +: 64] = mkw(regnum(r, k), 0);
            push_req(1'b1, r, 4'hF, d);
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic t_groups();
        run_group("R3", 1, 2, 3, 1'b1);
        run_group("R3", 31, 0, 16, 1'b1);
        run_group("R4", 4, 8, 9, 1'b0);
    endtask

    task automatic t_store();
        wait_slot(2'd0);
        mem_valid = 1'b1; mem_load = 1'b0; mem_row = 5'd20; mem_mask = '0; mem_wdata = '0;
        @(negedge clk); mem_valid = 1'b0;
        @(negedge clk);
        chk("R7", "rvalid before WR", 256'(mem_rvalid), 256'(0));
        @(negedge clk);
        chk("R7", "store rvalid", 256'(mem_rvalid), 256'(1));
        chk("R7", "store rdata", mem_rdata, row_of(20));
    endtask

    task automatic t_load_then_read();
        rowdat_t d;
        for (int k = 0; k < 4; k++) d[k*64 +: 64] = mkw(k, 32'h5A5A);
        wait_slot(2'd0);
        push_req(1'b1, 9, 4'b0101, d);   // R2: mask bits 0 and 2 pick lanes 0 and 2
        run_group("R9", 9, 9, 9, 1'b0);
        chk("R2", "reg 37 lane 1 kept", 256'(rf_ref[37]), 256'(mkw(37, 0)));
    endtask

    task automatic t_writeback();
        rowdat_t old12, ez;
        word_t d1, d3;
        d1 = mkw(7, 32'h1111); d3 = mkw(8, 32'h3333);
        old12 = row_of(12); ez = '0;
        @(negedge clk);
        res_valid = 1'b1; res_lane = 2'd1; res_data = d1; res_last = 1'b0; res_row = 5'd12;
        @(negedge clk); res_valid = 1'b0;
        wait_slot(2'd0);
        res_valid = 1'b1; res_lane = 2'd3; res_data = d3; res_last = 1'b1; res_row = 5'd12;
        drive_grp(12, 12, 0, 1'b0);
        @(negedge clk); res_valid = 1'b0; res_last = 1'b0; grp_valid = 1'b0;
        repeat (3) @(negedge clk);
        expect_lanes("R5", old12, old12, ez);
        rf_ref[regnum(12, 1)] = d1;
        rf_ref[regnum(12, 3)] = d3;
        run_group("R6", 12, 3, 3, 1'b0);
    endtask

    task automatic t_arbitration();
        rowdat_t old7, da, db, e0, e1;
        for (int k = 0; k < 4; k++) begin
            da[k*64 +: 64] = mkw(k, 32'hAAAA);
            db[k*64 +: 64] = mkw(k, 32'hBBBB);
        end
        old7 = row_of(7); e0 = row_of(0); e1 = row_of(1);
        wait_slot(2'd0);
        drive_grp(5, 6, 7, 1'b1);
        mem_valid = 1'b1; mem_load = 1'b1; mem_row = 5'd7; mem_mask = 4'hF; mem_wdata = da;
        @(negedge clk);
        grp_valid = 1'b0;
        chk("R8", "ready with one waiting", 256'(mem_ready), 256'(1));
        mem_wdata = db;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R8", "ready low when full", 256'(mem_ready), 256'(0));
        @(negedge clk);
        @(negedge clk);
        drive_grp(0, 1, 7, 1'b1);
        @(negedge clk); grp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "still full while S3 busy", 256'(mem_ready), 256'(0));
        expect_lanes("R8", e0, e1, old7);
        repeat (8) @(negedge clk);
        for (int k = 0; k < 4; k++) rf_ref[regnum(7, k)] = db[k*64 +: 64];
        run_group("R8", 7, 7, 7, 1'b1);
    endtask

    initial begin
        grp_valid = 1'b0; grp_use_s3 = 1'b0; grp_src1 = '0; grp_src2 = '0; grp_src3 = '0;
        res_valid = 1'b0; res_last = 1'b0; res_lane = '0; res_row = '0; res_data = '0;
        mem_valid = 1'b0; mem_load = 1'b0; mem_row = '0; mem_mask = '0; mem_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_slots();
        t_fill();
        t_groups();
        t_store();
        t_load_then_read();
        t_writeback();
        t_arbitration();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule